// File: doc/BRIEF.md
# Serial-Bus Frequency Synthesiser Control Interface

This block is the two-wire serial (I2C) slave that holds the programmable state of a frequency synthesiser. A bus master writes it a 15-bit loop divider ratio, a charge-pump current select, a two-bit test-mode select, a tuning-output disable and six port latches. The master can also read back one status byte. The status byte reports a power-up flag, the loop lock flag, the levels sensed on three ports, and a 3-bit band code. The band code is encoded from a five-line thermometer input that an external comparator bank drives.

A two-bit strap selects the slave address. The strap value 01 accepts any value of the two selectable address bits. There is no sub-address. The MSB of each data byte decides its role: a byte with MSB 0 opens a divider pair, and a byte with MSB 1 opens a control pair. The divider ratio is applied only when its whole pair has arrived. SCL, SDA and all status inputs pass through two-flop synchronisers, and the block samples them on the system clock. The SDA output is an open-drain pull-down enable.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The address byte is 1,1,0,0,0,s1,s0,rw, sent MSB first. The slave acknowledges it only when the top five bits match and either addr_sel is 01 or s1s0 equals addr_sel. After an address that is not acknowledged, the following bytes get no acknowledge and leave every output unchanged.
- R2: Each data byte of a write to a matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: A data byte with bit 7 = 0 opens a divider pair. Its bits 6:0 become div_ratio[14:8] and the next byte becomes div_ratio[7:0]. div_ratio changes only when that second byte arrives. A pair cut off by STOP or START is discarded.
- R4: A data byte with bit 7 = 1 opens a control pair. Its bit 6 drives cp_sel, its bits 5:4 drive test_sel, and its bit 0 drives out_off. In the next byte, bits 7..3 go to port_drv[5:1] and bit 0 goes to port_drv[0]. Bits 2:1 of that byte have no effect.
- R5: Pairs may come in any order, and several pairs may come in one transfer. The last value of each register wins.
- R6: A read returns a status byte, sent MSB first, laid out as {por, lock_i, port_in[2:0], code[2:0]}.
- R7: code is the index of the highest set bit of therm_i[4:0], or 0 when none is set. Bit 0 therefore never changes the code.
- R8: The por flag reads 1 after reset. It clears once the first status byte has been fully sent, and it stays 0 after that.
- R9: A master acknowledge after a status byte makes the block send the status byte again. A master no-acknowledge ends the read, and SDA is released.
- R10: After reset, div_ratio is 0, cp_sel is 0, test_sel is 0, out_off is 0, port_drv is all ones (released), and sda_oe is 0.
- R11: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Address strap; 01 accepts any selectable address bits |
| lock_i | input | 1 | Loop lock flag |
| port_in | input | 3 | Sensed port levels, reported in status bits 5:3 |
| therm_i | input | 5 | Thermometer lines from the comparator bank |
| div_ratio | output | 15 | Loop divider ratio |
| cp_sel | output | 1 | Charge-pump current select |
| test_sel | output | 2 | Test-mode select |
| out_off | output | 1 | Tuning-drive output disable |
| port_drv | output | 6 | Port latches, 1 = released |

## Verification
The hardest case to reach is a divider pair that is cut in half. This happens when a STOP ends the transfer after the first divider byte. It also happens when the next transfer opens with a byte that is then taken as a new first byte, not as the missing low half. The bench builds both cases on purpose and checks that div_ratio holds and then takes only the new complete pair. It also sweeps every combination of strap and address bits, so the always-accept strap value is exercised. The bench reads status across all 32 thermometer patterns. The first read of the run is used to show the power-up flag clearing exactly once.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } bus_st_e;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;
  localparam logic [1:0] SEL_ANY     = 2'b01;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/band_encode.sv
module band_encode #(
  parameter int NBAND  = 5,
  localparam int CODE_W = $clog2(NBAND)
) (
  input  logic [NBAND-1:0]  therm,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < NBAND; i++) begin
      if (therm[i]) code = CODE_W'(i);
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status,
  output logic [7:0] wr_byte,
  output logic       wr_vld,
  output logic       frame_edge,
  output logic       rd_done,
  output logic       sda_oe
);
  bus_st_e    st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       oe_q, oe_n, rw_q, rw_n, vld_n, done_n, edge_n;
  logic       scl_d, sda_d;
  logic       scl_rise, scl_fall, start_det, stop_det, addr_ok;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign addr_ok   = (sh_q[7:3] == ADDR_PREFIX) &&
                     ((addr_sel == SEL_ANY) || (sh_q[2:1] == addr_sel));

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; oe_n = oe_q; rw_n = rw_q;
    vld_n = 1'b0; done_n = 1'b0; edge_n = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE; oe_n = 1'b0; edge_n = 1'b1;
    end else if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; oe_n = 1'b0; edge_n = 1'b1;
    end else begin
      case (st_q)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_n = '0;
            if (st_q == ST_WBYTE) begin
              st_n = ST_WACK; oe_n = 1'b1; vld_n = 1'b1;
            end else if (addr_ok) begin
              st_n = ST_AACK; oe_n = 1'b1; rw_n = sh_q[0];
              if (sh_q[0]) sh_n = status;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw_q) begin st_n = ST_RBYTE; oe_n = ~sh_q[7]; end
          else      begin st_n = ST_WBYTE; oe_n = 1'b0;     end
        end
        ST_WACK: if (scl_fall) begin
          st_n = ST_WBYTE; oe_n = 1'b0;
        end
        ST_RBYTE: begin
          if (scl_rise) cnt_n = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_n = ST_RACK; oe_n = 1'b0; cnt_n = '0;
            end else begin
              sh_n = {sh_q[6:0], 1'b0}; oe_n = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            done_n = 1'b1;
            if (sda_s) st_n = ST_IDLE;
          end else if (scl_fall) begin
            st_n = ST_RBYTE; sh_n = status; oe_n = ~status[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; oe_q <= 1'b0; rw_q <= 1'b0;
      wr_vld <= 1'b0; rd_done <= 1'b0; frame_edge <= 1'b0;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; oe_q <= oe_n; rw_q <= rw_n;
      wr_vld <= vld_n; rd_done <= done_n; frame_edge <= edge_n;
      scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  assign wr_byte = sh_q;
  assign sda_oe  = oe_q;

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_s);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c #(
  parameter int DIV_W  = 15,
  parameter int NPORT  = 6,
  parameter int NSENSE = 3,
  parameter int NBAND  = 5,
  parameter int SYNC_N = 2,
  localparam int CODE_W = $clog2(NBAND),
  localparam int STAT_W = 1 + NSENSE + NBAND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic [NSENSE-1:0] port_in,
  input  logic [NBAND-1:0]  therm_i,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              cp_sel,
  output logic [1:0]        test_sel,
  output logic              out_off,
  output logic [NPORT-1:0]  port_drv
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic              scl_s, sda_s, lock_s;
  logic [NSENSE-1:0] port_s;
  logic [NBAND-1:0]  therm_s;
  logic [CODE_W-1:0] code;

  ctl_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_s_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));
  ctl_sync #(.W(STAT_W), .STAGES(SYNC_N), .RST_VAL('0)) u_stat_sync (
    .clk(clk), .rst_n(rst_s_n), .d({lock_i, port_in, therm_i}),
    .q({lock_s, port_s, therm_s}));
  band_encode #(.NBAND(NBAND)) u_enc (.therm(therm_s), .code(code));

  logic       por_q, por_n;
  logic [7:0] wr_byte;
  logic       wr_vld, frame_edge, rd_done;

  i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_s_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_sel(addr_sel), .status({por_q, lock_s, port_s, code}),
    .wr_byte(wr_byte), .wr_vld(wr_vld), .frame_edge(frame_edge),
    .rd_done(rd_done), .sda_oe(sda_oe));

  logic             phase_q, phase_n, kind_q, kind_n;
  logic [6:0]       first_q, first_n;
  logic [DIV_W-1:0] div_n;
  logic             cp_n, od_n;
  logic [1:0]       test_n;
  logic [NPORT-1:0] port_n;

  always_comb begin
    phase_n = phase_q; kind_n = kind_q; first_n = first_q;
    div_n = div_ratio; cp_n = cp_sel; test_n = test_sel; od_n = out_off;
    port_n = port_drv;
    por_n = por_q & ~rd_done;
    if (frame_edge) begin
      phase_n = 1'b0;
    end else if (wr_vld) begin
      if (!phase_q) begin
        phase_n = 1'b1; kind_n = wr_byte[7]; first_n = wr_byte[6:0];
      end else begin
        phase_n = 1'b0;
        if (!kind_q) begin
          div_n = DIV_W'({first_q, wr_byte});
        end else begin
          cp_n = first_q[6]; test_n = first_q[5:4]; od_n = first_q[0];
          port_n = NPORT'({wr_byte[7:3], wr_byte[0]});
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= 1'b0; kind_q <= 1'b0; first_q <= '0; por_q <= 1'b1;
      div_ratio <= '0; cp_sel <= 1'b0; test_sel <= '0; out_off <= 1'b0;
      port_drv <= '1;
    end else begin
      phase_q <= phase_n; kind_q <= kind_n; first_q <= first_n; por_q <= por_n;
      div_ratio <= div_n; cp_sel <= cp_n; test_sel <= test_n; out_off <= od_n;
      port_drv <= port_n;
    end
  end

  assert_div_atomic_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(div_ratio) |-> $past(wr_vld && phase_q && !kind_q));
  assert_port_pair_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(port_drv) |-> $past(wr_vld && phase_q && kind_q));
  assert_por_sticky_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(por_q) |-> !por_q);
endmodule

// File: tb/sim_synth_ctl_i2c.sv
module sim_synth_ctl_i2c;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, lock_i, cp_sel, out_off, sda_oe;
  logic [1:0] addr_sel, test_sel;
  logic [2:0] port_in;
  logic [4:0] therm_i;
  logic [14:0] div_ratio;
  logic [5:0] port_drv;
  wire sda_bus = sda_m & ~sda_oe;

  synth_ctl_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .port_in(port_in), .therm_i(therm_i),
    .div_ratio(div_ratio), .cp_sel(cp_sel), .test_sel(test_sel),
    .out_off(out_off), .port_drv(port_drv));

  localparam int Q = 6;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait; sda_m = 1'b0; qwait; scl_m = 1'b0; qwait;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; qwait; scl_m = 1'b1; qwait; sda_m = 1'b1; qwait; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait; scl_m = 1'b1; qwait; qwait; scl_m = 1'b0; qwait;
    end
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait; ack = ~sda_bus; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait; scl_m = 1'b1; qwait; d[i] = sda_bus; qwait; scl_m = 1'b0; qwait;
    end
    sda_m = ~mack; qwait; scl_m = 1'b1; qwait; qwait; scl_m = 1'b0; qwait;
    sda_m = 1'b1; qwait;
  endtask

  task automatic write_pair(input logic [7:0] b0, input logic [7:0] b1, input string tag);
    logic a;
    send_byte(b0, a); chk(tag, a, 1);
    send_byte(b1, a); chk(tag, a, 1);
  endtask

  task automatic write_div(input logic [14:0] v);
    logic a;
    i2c_start; send_byte({5'b11000, addr_sel, 1'b0}, a); chk("R1 addr ack", a, 1);
    write_pair({1'b0, v[14:8]}, v[7:0], "R2 div byte ack");
    i2c_stop;
  endtask

  function automatic logic [2:0] exp_code(input logic [4:0] t);
    logic [2:0] c = 3'd0;
    for (int i = 1; i < 5; i++) if (t[i]) c = 3'(i);
    return c;
  endfunction

  task automatic do_read(input logic mack, output logic [7:0] s0, output logic [7:0] s1);
    logic a;
    i2c_start; send_byte({5'b11000, addr_sel, 1'b1}, a); chk("R6 read addr ack", a, 1);
    read_byte(mack, s0);
    s1 = s0;
    if (mack) read_byte(1'b0, s1);
    chk("R9 sda released after nack", sda_oe, 0);
    i2c_stop;
  endtask

  initial begin
    logic a;
    logic [14:0] exp_div;
    logic [7:0] s0, s1;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 2'b00;
    lock_i = 1'b0; port_in = 3'b000; therm_i = 5'b00000;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1; qwait;
    chk("R10 div reset", div_ratio, 0);
    chk("R10 cp reset", cp_sel, 0);
    chk("R10 test reset", test_sel, 0);
    chk("R10 off reset", out_off, 0);
    chk("R10 ports reset", port_drv, 6'h3F);
    chk("R10 sda reset", sda_oe, 0);

    // R1: every strap against every address field; nacked bytes must not land
    exp_div = 15'd0;
    for (int sel = 0; sel < 4; sel++) begin
      for (int ma = 0; ma < 4; ma++) begin
        logic hit;
        logic [14:0] v;
        addr_sel = 2'(sel);
        hit = (sel == 1) || (ma == sel);
        v = 15'(16'h0100 + sel * 4 + ma);
        i2c_start; send_byte({5'b11000, 2'(ma), 1'b0}, a);
        chk("R1 address match", a, 32'(hit));
        send_byte({1'b0, v[14:8]}, a); chk("R1 data after mismatch", a, 32'(hit));
        send_byte(v[7:0], a);          chk("R1 data after mismatch", a, 32'(hit));
        i2c_stop;
        if (hit) exp_div = v;
        chk("R1 div after address test", div_ratio, exp_div);
      end
    end
    addr_sel = 2'b10;
    i2c_start; send_byte({5'b11001, 2'b10, 1'b0}, a); i2c_stop;
    chk("R1 wrong prefix nack", a, 0);

    // R3: divider sweep including extremes
    for (int k = 0; k < 18; k++) begin
      logic [14:0] v;
      v = (k == 16) ? 15'h7FFF : (k == 17) ? 15'h0000 : 15'((k * 4951 + k * k * 31) & 32'h7FFF);
      write_div(v);
      chk("R3 divider value", div_ratio, v);
    end
    write_div(15'h2A5C);
    // R3: half pair then STOP, then a fresh transfer restarting the pair
    i2c_start; send_byte({5'b11000, addr_sel, 1'b0}, a);
    send_byte(8'h55, a); i2c_stop;
    chk("R3 half pair held", div_ratio, 15'h2A5C);
    i2c_start; send_byte({5'b11000, addr_sel, 1'b0}, a);
    send_byte(8'h11, a);
    qwait;
    chk("R3 first byte only held", div_ratio, 15'h2A5C);
    send_byte(8'h22, a); i2c_stop;
    chk("R3 new pair after abort", div_ratio, 15'h1122);

    // R4: control pair sweep; bits 2:1 of port byte ignored
    for (int c = 0; c < 16; c++) begin
      logic [7:0] p;
      p = 8'((c * 37 + 5) & 255);
      i2c_start; send_byte({5'b11000, addr_sel, 1'b0}, a);
      write_pair({1'b1, c[0], c[2:1], 3'b111, c[3]}, p, "R4 ctrl byte ack");
      i2c_stop;
      chk("R4 cp_sel", cp_sel, 32'(c[0]));
      chk("R4 test_sel", test_sel, 32'(c[2:1]));
      chk("R4 out_off", out_off, 32'(c[3]));
      chk("R4 port_drv", port_drv, {p[7:3], p[0]});
    end
    chk("R3 div untouched by control", div_ratio, 15'h1122);

    // R5: mixed pairs in one transfer
    i2c_start; send_byte({5'b11000, addr_sel, 1'b0}, a);
    write_pair(8'hCE, 8'h00, "R5 ack");
    write_pair(8'h3A, 8'hBC, "R5 ack");
    write_pair(8'h8F, 8'hF9, "R5 ack");
    i2c_stop;
    chk("R5 divider", div_ratio, 15'h3ABC);
    chk("R5 cp last wins", cp_sel, 0);
    chk("R5 test last wins", test_sel, 0);
    chk("R5 off last wins", out_off, 1);
    chk("R5 ports last wins", port_drv, 6'h3F);

    // R6/R8: first read shows power-up flag, second does not
    lock_i = 1'b1; port_in = 3'b101; therm_i = 5'b00111; qwait;
    do_read(1'b0, s0, s1);
    chk("R8 por set on first read", s0, {1'b1, 1'b1, 3'b101, 3'd2});
    do_read(1'b0, s0, s1);
    chk("R8 por cleared", s0, {1'b0, 1'b1, 3'b101, 3'd2});

    // R7: all thermometer patterns
    for (int t = 0; t < 32; t++) begin
      therm_i = 5'(t); port_in = 3'(t) ^ 3'b010; lock_i = t[3]; qwait;
      do_read(1'b0, s0, s1);
      chk("R7 status code", s0, {1'b0, lock_i, port_in, exp_code(5'(t))});
    end

    // R9: master ack repeats the status byte
    therm_i = 5'b10001; port_in = 3'b011; lock_i = 1'b0; qwait;
    do_read(1'b1, s0, s1);
    chk("R9 first byte", s0, {1'b0, 1'b0, 3'b011, 3'd4});
    chk("R9 repeated byte", s1, {1'b0, 1'b0, 3'b011, 3'd4});

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule